// File: doc/BRIEF.md
# DDR Command Turnaround Spacing Gate

This block sits between a DDR command scheduler and the memory command bus. It holds back each candidate command until the minimum clock gap to the last read or write has passed. The gap depends on whether the candidate reverses the data direction, moves to another chip select, or repeats the same command type on the same rank. Each reversal gap starts from a default that comes from the CAS latency, the write latency and the burst length. A 0–3 cycle programmable extra is then added to it. The block also keeps every command back for a programmed number of clocks after the scheduler signals a wake from either kind of power-down.

Commands use a valid/ready handshake. The scheduler presents a command with `cmd_valid`, `cmd_type` and `cmd_cs`. `cmd_ready` rises in the first cycle in which that command is allowed to go out. The grant outputs mirror the accepted command in the same cycle. Two state machines carry the timing. The reference machine has states REF_NONE, REF_AFTER_RD and REF_AFTER_WR. It moves to REF_AFTER_RD on every granted read and to REF_AFTER_WR on every granted write, from any state. It leaves its state unchanged on other commands, and it returns to REF_NONE only on reset. The wake machine has states PDX_RUN and PDX_WAIT. It enters PDX_WAIT on a wake pulse whose wait is longer than one clock. It returns to PDX_RUN when its count runs out, and it starts a fresh count on any later pulse.

Top module: `ddr_turnaround_gate`

## Requirements
- R1: After a granted read (`cmd_type`=01), a write (`cmd_type`=10) to any chip select is granted no earlier than N cycles later. N = max(1, ceil(CL) − WL + BL/2 + 2) + `cfg_add_rd2wr`. CL = `cfg_cl_half`/2, and BL/2 is 2 for 4-beat bursts and 4 for 8-beat bursts. A grant N cycles later means a back-to-back grant when N=1.
- R2: After a granted write, a read to any chip select waits N = max(1, WL − floor(CL) + BL/2 + 1) + `cfg_add_wr2rd` cycles.
- R3: A read to a different chip select than the last read waits 3 + `cfg_add_rd2rd` cycles, or 5 + `cfg_add_rd2rd` with effective 8-beat bursts. A write to a different chip select than the last write waits 2 + `cfg_add_wr2wr` cycles, or 4 + `cfg_add_wr2wr` with effective 8-beat bursts.
- R4: A read after a read, or a write after a write, to the same chip select waits exactly BL/2 cycles, with no extra added.
- R5: Commands with `cmd_type` 00 or 11 ("other") are never held by turnaround spacing. They do not change the reference: the next read or write is timed from the last read or write.
- R6: A wake pulse (`apd_wake` or `ppd_wake`) in cycle t blocks all commands in cycle t. The first command may then be granted in cycle t+N, where N is the 3-bit code of that wake. If both pulse together, the larger N applies.
- R7: A wake code of 000 waits 1 clock and sets `cfg_err`. `cfg_err` stays set until reset.
- R8: After reset there is no reference: a read or write is ready at once, and `cfg_err` is 0.
- R9: `cmd_ready` stays low until the required gap has passed. The command is then granted in the first allowed cycle. `grant_type` and `grant_cs` equal the presented command whenever `grant_valid` is 1.
- R10: When `cfg_ddr2`=1, `cfg_bl8` is ignored. All gaps use the 4-beat values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl_half | input | CLH_W | CAS latency in half-cycle units |
| cfg_wl | input | WL_W | Write latency in cycles |
| cfg_bl8 | input | 1 | Request 8-beat bursts |
| cfg_ddr2 | input | 1 | DDR2 mode (forces 4-beat timing) |
| cfg_add_rd2wr | input | 2 | Extra cycles, read to write |
| cfg_add_wr2rd | input | 2 | Extra cycles, write to read |
| cfg_add_rd2rd | input | 2 | Extra cycles, read to read on another chip select |
| cfg_add_wr2wr | input | 2 | Extra cycles, write to write on another chip select |
| cfg_apd_wake | input | 3 | Wait after active power-down wake (000 reserved) |
| cfg_ppd_wake | input | 3 | Wait after precharge power-down wake (000 reserved) |
| apd_wake | input | 1 | Pulse: active power-down wake this cycle |
| ppd_wake | input | 1 | Pulse: precharge power-down wake this cycle |
| cmd_valid | input | 1 | Candidate command present |
| cmd_type | input | 2 | 01 read, 10 write, 00/11 other |
| cmd_cs | input | CS_W | Candidate chip select |
| cmd_ready | output | 1 | Candidate may be issued this cycle |
| grant_valid | output | 1 | Command issued this cycle |
| grant_type | output | 2 | Type of issued command |
| grant_cs | output | CS_W | Chip select of issued command |
| cfg_err | output | 1 | Sticky flag: reserved wake code was used |

## Verification
The hardest case to reach from the ports is an "other" command granted inside a read-to-write window, followed by a write. The bench chains three commands on consecutive cycles. It shows that the other goes out at once, and that the write still counts from the read and not from the other. The gap measurement counts cycles from one observed grant to the next. The odd half-cycle CAS settings are chosen so that rounding in the wrong direction changes the measured gap by one. For wakes, the bench raises both pulses in one cycle with different codes, and then a reserved code, to reach the longer-wins path and the sticky flag.

// File: rtl/ddr_tg_pkg.sv
package ddr_tg_pkg;

    localparam int GAP_W   = 6;
    localparam int GAP_MAX = (1 << GAP_W) - 1;

    localparam logic [1:0] CMD_RD = 2'b01;
    localparam logic [1:0] CMD_WR = 2'b10;

    typedef enum logic [1:0] {
        REF_NONE     = 2'd0,
        REF_AFTER_RD = 2'd1,
        REF_AFTER_WR = 2'd2
    } ref_state_e;

    typedef enum logic {
        PDX_RUN  = 1'b0,
        PDX_WAIT = 1'b1
    } pdx_state_e;

    typedef struct packed {
        logic [GAP_W-1:0] rw;
        logic [GAP_W-1:0] wr;
        logic [GAP_W-1:0] rr_diff;
        logic [GAP_W-1:0] ww_diff;
        logic [GAP_W-1:0] same;
    } gap_set_t;

endpackage

// File: rtl/ddr_tg_gap_calc.sv
module ddr_tg_gap_calc
    import ddr_tg_pkg::*;
#(
    parameter int CLH_W = 5,
    parameter int WL_W  = 4
) (
    input  logic [CLH_W-1:0] cfg_cl_half,
    input  logic [WL_W-1:0]  cfg_wl,
    input  logic             bl8_eff,
    input  logic [1:0]       add_rw,
    input  logic [1:0]       add_wr,
    input  logic [1:0]       add_rr,
    input  logic [1:0]       add_ww,
    output gap_set_t         gaps
);

    // Clamp a derived default to at least one cycle, add the extra, saturate.
    function automatic logic [GAP_W-1:0] fit(input int base, input logic [1:0] extra);
        int v;
        v = (base < 1) ? 1 : base;
        v = v + int'(extra);
        if (v > GAP_MAX) v = GAP_MAX;
        return GAP_W'(v);
    endfunction

    int cl_up;
    int cl_dn;
    int wl_i;
    int half_bl;

    always_comb begin
        cl_up   = (int'(cfg_cl_half) + 1) / 2;
        cl_dn   = int'(cfg_cl_half) / 2;
        wl_i    = int'(cfg_wl);
        half_bl = bl8_eff ? 4 : 2;

        gaps.rw      = fit(cl_up - wl_i + half_bl + 2, add_rw);
        gaps.wr      = fit(wl_i - cl_dn + half_bl + 1, add_wr);
        gaps.rr_diff = fit(bl8_eff ? 5 : 3, add_rr);
        gaps.ww_diff = fit(bl8_eff ? 4 : 2, add_ww);
        gaps.same    = fit(half_bl, 2'd0);
    end

endmodule

// File: rtl/ddr_tg_spacing.sv
module ddr_tg_spacing
    import ddr_tg_pkg::*;
#(
    parameter int CS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  gap_set_t        gaps,
    input  logic [1:0]      cand_type,
    input  logic [CS_W-1:0] cand_cs,
    input  logic            take,
    input  logic [1:0]      take_type,
    input  logic [CS_W-1:0] take_cs,
    output logic            space_ok
);

    localparam logic [GAP_W-1:0] SAT = GAP_W'(GAP_MAX);

    ref_state_e       state_q, state_d;
    logic [CS_W-1:0]  last_cs_q;
    logic [GAP_W-1:0] elapsed_q;
    logic [GAP_W-1:0] need;
    logic             take_rdwr;

    assign take_rdwr = take && (take_type == CMD_RD || take_type == CMD_WR);

    // Transitions: any state -> REF_AFTER_RD on read grant,
    // any state -> REF_AFTER_WR on write grant, otherwise hold.
    always_comb begin
        state_d = state_q;
        if (take) begin
            unique case (take_type)
                CMD_RD:  state_d = REF_AFTER_RD;
                CMD_WR:  state_d = REF_AFTER_WR;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= REF_NONE;
            last_cs_q <= '0;
            elapsed_q <= SAT;
        end else begin
            state_q <= state_d;
            if (take_rdwr) begin
                last_cs_q <= take_cs;
                elapsed_q <= GAP_W'(1);
            end else if (elapsed_q != SAT) begin
                elapsed_q <= elapsed_q + GAP_W'(1);
            end
        end
    end

    always_comb begin
        need = '0;
        unique case (state_q)
            REF_NONE: need = '0;
            REF_AFTER_RD: begin
                if (cand_type == CMD_RD)
                    need = (cand_cs == last_cs_q) ? gaps.same : gaps.rr_diff;
                else if (cand_type == CMD_WR)
                    need = gaps.rw;
            end
            REF_AFTER_WR: begin
                if (cand_type == CMD_WR)
                    need = (cand_cs == last_cs_q) ? gaps.same : gaps.ww_diff;
                else if (cand_type == CMD_RD)
                    need = gaps.wr;
            end
            default: need = '0;
        endcase
        space_ok = (elapsed_q >= need);
    end

endmodule

// File: rtl/ddr_tg_pdx.sv
module ddr_tg_pdx
    import ddr_tg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apd_wake,
    input  logic       ppd_wake,
    input  logic [2:0] apd_code,
    input  logic [2:0] ppd_code,
    output logic       pd_ok,
    output logic       cfg_err
);

    pdx_state_e st_q, st_d;
    logic [2:0] cnt_q, cnt_d;
    logic [2:0] a_eff, p_eff, len;
    logic       pulse;
    logic       bad_code;

    assign pulse    = apd_wake || ppd_wake;
    assign a_eff    = (apd_code == 3'd0) ? 3'd1 : apd_code;
    assign p_eff    = (ppd_code == 3'd0) ? 3'd1 : ppd_code;
    assign bad_code = (apd_wake && apd_code == 3'd0) || (ppd_wake && ppd_code == 3'd0);

    always_comb begin
        len = 3'd0;
        if (apd_wake) len = a_eff;
        if (ppd_wake && p_eff > len) len = p_eff;
    end

    // Transitions: any state -> PDX_WAIT on a wake longer than one clock,
    // any state -> PDX_RUN on a one-clock wake, PDX_WAIT -> PDX_RUN at count end.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (pulse) begin
            cnt_d = len - 3'd1;
            st_d  = (len > 3'd1) ? PDX_WAIT : PDX_RUN;
        end else begin
            unique case (st_q)
                PDX_RUN:  cnt_d = cnt_q;
                PDX_WAIT: begin
                    cnt_d = cnt_q - 3'd1;
                    if (cnt_q == 3'd1) st_d = PDX_RUN;
                end
                default:  st_d = PDX_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= PDX_RUN;
            cnt_q   <= 3'd0;
            cfg_err <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            cfg_err <= cfg_err || bad_code;
        end
    end

    always_comb begin
        pd_ok = (st_q == PDX_RUN) && !pulse;
    end

endmodule

// File: rtl/ddr_turnaround_gate.sv
module ddr_turnaround_gate
    import ddr_tg_pkg::*;
#(
    parameter int CLH_W = 5,
    parameter int WL_W  = 4,
    parameter int CS_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLH_W-1:0] cfg_cl_half,
    input  logic [WL_W-1:0]  cfg_wl,
    input  logic             cfg_bl8,
    input  logic             cfg_ddr2,
    input  logic [1:0]       cfg_add_rd2wr,
    input  logic [1:0]       cfg_add_wr2rd,
    input  logic [1:0]       cfg_add_rd2rd,
    input  logic [1:0]       cfg_add_wr2wr,
    input  logic [2:0]       cfg_apd_wake,
    input  logic [2:0]       cfg_ppd_wake,
    input  logic             apd_wake,
    input  logic             ppd_wake,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_type,
    input  logic [CS_W-1:0]  cmd_cs,
    output logic             cmd_ready,
    output logic             grant_valid,
    output logic [1:0]       grant_type,
    output logic [CS_W-1:0]  grant_cs,
    output logic             cfg_err
);

    gap_set_t gaps;
    logic     bl8_eff;
    logic     space_ok;
    logic     pd_ok;

    assign bl8_eff = cfg_bl8 && !cfg_ddr2;

    ddr_tg_gap_calc #(.CLH_W(CLH_W), .WL_W(WL_W)) u_gap (
        .cfg_cl_half (cfg_cl_half),
        .cfg_wl      (cfg_wl),
        .bl8_eff     (bl8_eff),
        .add_rw      (cfg_add_rd2wr),
        .add_wr      (cfg_add_wr2rd),
        .add_rr      (cfg_add_rd2rd),
        .add_ww      (cfg_add_wr2wr),
        .gaps        (gaps)
    );

    ddr_tg_spacing #(.CS_W(CS_W)) u_space (
        .clk       (clk),
        .rst_n     (rst_n),
        .gaps      (gaps),
        .cand_type (cmd_type),
        .cand_cs   (cmd_cs),
        .take      (grant_valid),
        .take_type (grant_type),
        .take_cs   (grant_cs),
        .space_ok  (space_ok)
    );

    ddr_tg_pdx u_pdx (
        .clk      (clk),
        .rst_n    (rst_n),
        .apd_wake (apd_wake),
        .ppd_wake (ppd_wake),
        .apd_code (cfg_apd_wake),
        .ppd_code (cfg_ppd_wake),
        .pd_ok    (pd_ok),
        .cfg_err  (cfg_err)
    );

    always_comb begin
        cmd_ready   = pd_ok && space_ok;
        grant_valid = cmd_valid && cmd_ready;
        grant_type  = cmd_type;
        grant_cs    = cmd_cs;
    end

endmodule

// File: rtl/ddr_tg_checker.sv
module ddr_tg_checker
    import ddr_tg_pkg::*;
#(
    parameter int CS_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            apd_wake,
    input logic            ppd_wake,
    input logic [2:0]      cfg_apd_wake,
    input logic [2:0]      cfg_ppd_wake,
    input logic            cmd_ready,
    input logic            grant_valid,
    input logic [1:0]      grant_type,
    input logic [CS_W-1:0] grant_cs,
    input logic            cfg_err
);

    assert_wake_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (apd_wake || ppd_wake) |-> !cmd_ready);

    assert_wake_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((apd_wake && cfg_apd_wake >= 3'd2) || (ppd_wake && cfg_ppd_wake >= 3'd2)) |=> !cmd_ready);

    assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((apd_wake && cfg_apd_wake == 3'd0) || (ppd_wake && cfg_ppd_wake == 3'd0)) |=> cfg_err);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R3 and R4: two reads are always at least two cycles apart on any chip select.
    assert_rd_rd_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_type == CMD_RD) |=> !(grant_valid && grant_type == CMD_RD));

    assert_wr_wr_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_type == CMD_WR) |=> !(grant_valid && grant_type == CMD_WR));

    // R3: a read to another chip select never follows a read one cycle later.
    assert_rd_cs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_type == CMD_RD) |=>
            !(grant_valid && grant_type == CMD_RD && grant_cs != $past(grant_cs)));

endmodule

bind ddr_turnaround_gate ddr_tg_checker #(.CS_W(CS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .apd_wake     (apd_wake),
    .ppd_wake     (ppd_wake),
    .cfg_apd_wake (cfg_apd_wake),
    .cfg_ppd_wake (cfg_ppd_wake),
    .cmd_ready    (cmd_ready),
    .grant_valid  (grant_valid),
    .grant_type   (grant_type),
    .grant_cs     (grant_cs),
    .cfg_err      (cfg_err)
);

// File: tb/tb_ddr_turnaround_gate.sv
`timescale 1ns/1ps
module tb_ddr_turnaround_gate;

    localparam logic [1:0] RD = 2'b01;
    localparam logic [1:0] WR = 2'b10;
    localparam logic [1:0] OT = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cfg_cl_half = 5'd6;
    logic [3:0] cfg_wl = 4'd2;
    logic       cfg_bl8 = 1'b0;
    logic       cfg_ddr2 = 1'b0;
    logic [1:0] cfg_add_rd2wr = 2'd0;
    logic [1:0] cfg_add_wr2rd = 2'd0;
    logic [1:0] cfg_add_rd2rd = 2'd0;
    logic [1:0] cfg_add_wr2wr = 2'd0;
    logic [2:0] cfg_apd_wake = 3'd1;
    logic [2:0] cfg_ppd_wake = 3'd1;
    logic       apd_wake = 1'b0;
    logic       ppd_wake = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_type = 2'b00;
    logic [1:0] cmd_cs = 2'd0;
    logic       cmd_ready;
    logic       grant_valid;
    logic [1:0] grant_type;
    logic [1:0] grant_cs;
    logic       cfg_err;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ddr_turnaround_gate dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_set(input int cl, input int wl, input bit bl8, input bit ddr2,
                           input int a_rw, input int a_wr, input int a_rr, input int a_ww);
        cfg_cl_half   = 5'(cl);
        cfg_wl        = 4'(wl);
        cfg_bl8       = bl8;
        cfg_ddr2      = ddr2;
        cfg_add_rd2wr = 2'(a_rw);
        cfg_add_wr2rd = 2'(a_wr);
        cfg_add_rd2rd = 2'(a_rr);
        cfg_add_wr2wr = 2'(a_ww);
    endtask

    // Idle long enough to clear any window, then issue one command.
    task automatic first_cmd(input logic [1:0] t, input logic [1:0] cs);
        int n;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (40) @(negedge clk);
        cmd_valid = 1'b1; cmd_type = t; cmd_cs = cs;
        n = 0;
        #1;
        while (!grant_valid && n < 100) begin
            @(negedge clk); #1; n++;
        end
    endtask

    // Present the next command one cycle after the last grant; gap in cycles.
    task automatic next_cmd(input logic [1:0] t, input logic [1:0] cs, output int gap);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_type = t; cmd_cs = cs;
        gap = 1;
        #1;
        while (!grant_valid && gap < 100) begin
            @(negedge clk); #1; gap++;
        end
    endtask

    task automatic pair(input logic [1:0] t1, input logic [1:0] c1,
                        input logic [1:0] t2, input logic [1:0] c2, output int gap);
        first_cmd(t1, c1);
        next_cmd(t2, c2, gap);
    endtask

    task automatic t_reset();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_type = RD; cmd_cs = 2'd1;
        #1;
        chk(cmd_ready == 1'b1, "R8 ready after reset", int'(cmd_ready), 1);
        chk(grant_valid == 1'b1, "R8 grant after reset", int'(grant_valid), 1);
        chk(cfg_err == 1'b0, "R8 err after reset", int'(cfg_err), 0);
        chk(grant_type == RD && grant_cs == 2'd1, "R9 grant mirrors command",
            int'({grant_type, grant_cs}), int'({RD, 2'd1}));
    endtask

    task automatic t_rd2wr();
        int g;
        cfg_set(6, 2, 0, 0, 0, 0, 0, 0);
        pair(RD, 0, WR, 0, g); chk(g == 5, "R1 rd->wr CL3 WL2", g, 5);
        cfg_set(6, 2, 0, 0, 3, 0, 0, 0);
        pair(RD, 0, WR, 2, g); chk(g == 8, "R1 rd->wr extra 3", g, 8);
        cfg_set(5, 2, 0, 0, 0, 0, 0, 0);
        pair(RD, 1, WR, 1, g); chk(g == 5, "R1 rd->wr CL2.5 rounds up", g, 5);
        cfg_set(4, 7, 0, 0, 0, 0, 0, 0);
        pair(RD, 0, WR, 0, g); chk(g == 1, "R1 rd->wr clamp to 1", g, 1);
    endtask

    task automatic t_wr2rd();
        int g;
        cfg_set(5, 2, 0, 0, 0, 0, 0, 0);
        pair(WR, 0, RD, 0, g); chk(g == 3, "R2 wr->rd CL2.5 rounds down", g, 3);
        cfg_set(5, 2, 0, 0, 0, 2, 0, 0);
        pair(WR, 0, RD, 3, g); chk(g == 5, "R2 wr->rd extra 2", g, 5);
        cfg_set(7, 2, 1, 0, 0, 0, 0, 0);
        pair(WR, 1, RD, 1, g); chk(g == 4, "R2 wr->rd CL3.5 BL8", g, 4);
        cfg_set(20, 1, 0, 0, 0, 0, 0, 0);
        pair(WR, 0, RD, 0, g); chk(g == 1, "R2 wr->rd clamp to 1", g, 1);
    endtask

    task automatic t_diff_cs();
        int g;
        cfg_set(6, 2, 0, 0, 0, 0, 0, 0);
        pair(RD, 0, RD, 1, g); chk(g == 3, "R3 rd->rd other cs BL4", g, 3);
        cfg_set(6, 2, 1, 0, 0, 0, 1, 0);
        pair(RD, 2, RD, 3, g); chk(g == 6, "R3 rd->rd other cs BL8 extra 1", g, 6);
        cfg_set(6, 2, 0, 0, 0, 0, 0, 0);
        pair(WR, 0, WR, 1, g); chk(g == 2, "R3 wr->wr other cs BL4", g, 2);
        cfg_set(6, 2, 1, 0, 0, 0, 0, 2);
        pair(WR, 1, WR, 0, g); chk(g == 6, "R3 wr->wr other cs BL8 extra 2", g, 6);
    endtask

    task automatic t_same_cs();
        int g;
        cfg_set(6, 2, 0, 0, 0, 0, 3, 3);
        pair(RD, 1, RD, 1, g); chk(g == 2, "R4 rd->rd same cs BL4 no extra", g, 2);
        cfg_set(6, 2, 1, 0, 0, 0, 3, 3);
        pair(WR, 2, WR, 2, g); chk(g == 4, "R4 wr->wr same cs BL8", g, 4);
    endtask

    task automatic t_ddr2();
        int g;
        cfg_set(6, 2, 1, 1, 0, 0, 0, 0);
        pair(RD, 0, RD, 1, g); chk(g == 3, "R10 DDR2 rd->rd other cs", g, 3);
        pair(RD, 0, WR, 0, g); chk(g == 5, "R10 DDR2 rd->wr uses BL4", g, 5);
        pair(WR, 3, WR, 3, g); chk(g == 2, "R10 DDR2 wr->wr same cs", g, 2);
    endtask

    task automatic t_other();
        int g;
        cfg_set(6, 2, 0, 0, 0, 0, 0, 0);
        pair(RD, 0, OT, 1, g); chk(g == 1, "R5 other not gated", g, 1);
        next_cmd(WR, 0, g);    chk(g == 4, "R5 write timed from read", g, 4);
        pair(WR, 0, 2'b11, 0, g); chk(g == 1, "R5 code 11 not gated", g, 1);
    endtask

    task automatic wake(input bit a, input bit p, input int ac, input int pc,
                        input logic [1:0] t, input int exp, input string req);
        int n;
        cfg_apd_wake = 3'(ac);
        cfg_ppd_wake = 3'(pc);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (40) @(negedge clk);
        apd_wake = a; ppd_wake = p;
        cmd_valid = 1'b1; cmd_type = t; cmd_cs = 2'd0;
        #1;
        chk(cmd_ready == 1'b0, req, int'(cmd_ready), 0);
        @(negedge clk);
        apd_wake = 1'b0; ppd_wake = 1'b0;
        n = 1;
        #1;
        while (!grant_valid && n < 100) begin
            @(negedge clk); #1; n++;
        end
        chk(n == exp, req, n, exp);
    endtask

    task automatic t_pd();
        cfg_set(6, 2, 0, 0, 0, 0, 0, 0);
        wake(1, 0, 4, 1, OT, 4, "R6 active wake 4");
        wake(0, 1, 1, 6, OT, 6, "R6 precharge wake 6");
        wake(1, 1, 2, 5, OT, 5, "R6 both wakes larger wins");
        wake(1, 0, 3, 1, RD, 3, "R6 wake before read");
        chk(cfg_err == 1'b0, "R7 no error on valid codes", int'(cfg_err), 0);
    endtask

    task automatic t_reserved();
        wake(1, 0, 0, 1, OT, 1, "R7 reserved code waits 1");
        chk(cfg_err == 1'b1, "R7 error set", int'(cfg_err), 1);
        repeat (5) @(negedge clk);
        chk(cfg_err == 1'b1, "R7 error sticky", int'(cfg_err), 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk(cfg_err == 1'b0, "R7 error cleared by reset", int'(cfg_err), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rd2wr();
        t_wr2rd();
        t_diff_cs();
        t_same_cs();
        t_ddr2();
        t_other();
        t_pd();
        t_reserved();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule